// File: doc/BRIEF.md
# Switching Amplifier Mode and Protection Controller

This block sits beside the power stage of a two-channel switching amplifier and decides, every clock cycle, what each output bridge is allowed to do: drive the audio, idle at an even 50% duty cycle, or float. It reads two level controls. One is a run enable; low means sleep. The other is a sound enable; low means silence. It also reads five protection flags from the analog comparators: supply over-limit, supply under-limit, over-current, thermal warning and thermal shutdown. All seven inputs pass through a two-stage synchronizer before the decision logic sees them.

Protection outranks the requested mode. Supply faults and thermal shutdown float every output and clear by themselves once their flag drops. Over-current floats the outputs for a programmed number of cycles. The block then looks again and starts a fresh interval if the flag is still set. The thermal warning only silences the outputs. A diagnostic drive signal, modelling an open-drain pin held low in normal running, lets go whenever any protection is in force. When the outputs leave any floating state, they spend a programmed number of cycles idling before audio may resume, which keeps speaker pops down.

Top module: `amp_guard_ctrl`

## Requirements
- R1: While the synchronized run enable is low and neither a supply fault, thermal shutdown nor over-current is pending, every channel command is 2'b00 (floating), whatever the sound enable.
- R2: With run enable high, sound enable low and no protection, every channel command is 2'b01 (50% idle). Raising the sound enable returns to 2'b10 in the usual latency, with no idle hold.
- R3: With run and sound enable both high and no protection, every channel command is 2'b10 (drive audio).
- R4: A supply over-limit, supply under-limit or thermal shutdown flag forces 2'b00 on every channel. Once all three are clear, the block recovers without any other input.
- R5: An over-current flag forces 2'b00 for exactly RETRY_CYC cycles. In the last cycle of that interval the flag is sampled again: if set, another full interval starts; if clear, recovery begins.
- R6: A thermal warning alone gives 2'b01 on every channel. When it clears, the block returns straight to the decoded mode with no idle hold.
- R7: diag_drive is 1 in normal running. It is 0 in the cycle after any synchronized flag is set and throughout an over-current interval.
- R8: Priority from highest to lowest: supply faults and thermal shutdown, over-current, run enable low, thermal warning, sound enable.
- R9: After any floating state (sleep, supply or thermal fault, over-current), the channels show 2'b01 for exactly QUIET_CYC cycles before 2'b10 may appear.
- R10: An input change first shows at the outputs after three rising edges: two synchronizer stages plus the state register.
- R11: While reset is asserted, every channel command is 2'b00 and diag_drive is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| run_en | input | 1 | Run enable; low requests sleep |
| sound_en | input | 1 | Sound enable; low requests silence |
| ov_flag | input | 1 | Supply above the upper limit |
| uv_flag | input | 1 | Supply below the lower limit |
| oc_flag | input | 1 | Output over-current |
| tw_flag | input | 1 | Die temperature at warning level |
| tsd_flag | input | 1 | Die temperature at shutdown level |
| chan_cmd | output | 2*NCH | Per-channel command, 2 bits per channel: 00 float, 01 idle 50%, 10 drive |
| diag_drive | output | 1 | 1 holds the diagnostic line low; 0 releases it |

## Verification
The assertions assume that every input is a level signal that stays steady for at least one clock. They also assume the flags are already free of glitches, so a one-cycle pulse counts as a real event and not as noise. The stimulus changes inputs only on the falling clock edge. After each change it holds the new values for longer than the synchronizer delay plus one full retry and idle window, so each steady result is sampled only after every timer has run out. The directed timing cases instead sample the cycles just before and just after each window boundary.

// File: rtl/agc_pkg.sv
package agc_pkg;

    typedef enum logic [2:0] {
        ST_SLEEP = 3'd0,
        ST_MUTE  = 3'd1,
        ST_PLAY  = 3'd2,
        ST_WARN  = 3'd3,
        ST_QUIET = 3'd4,
        ST_FAULT = 3'd5,
        ST_RETRY = 3'd6
    } agc_state_e;

    typedef enum logic [1:0] {
        CMD_FLOAT = 2'b00,
        CMD_IDLE  = 2'b01,
        CMD_DRIVE = 2'b10
    } chan_cmd_e;

    function automatic chan_cmd_e cmd_of(input agc_state_e st);
        case (st)
            ST_PLAY:                     return CMD_DRIVE;
            ST_MUTE, ST_WARN, ST_QUIET:  return CMD_IDLE;
            default:                     return CMD_FLOAT;
        endcase
    endfunction

endpackage

// File: rtl/agc_sync.sv
module agc_sync #(
    parameter int W      = 7,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] raw_i,
    output logic [W-1:0] sync_o
);

    logic [STAGES-1:0][W-1:0] pipe_d, pipe_q;

    always_comb begin
        pipe_d = {pipe_q[STAGES-2:0], raw_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= '0;
        else        pipe_q <= pipe_d;
    end

    assign sync_o = pipe_q[STAGES-1];

endmodule

// File: rtl/agc_fsm.sv
module agc_fsm
    import agc_pkg::*;
#(
    parameter int RETRY_CYC = 20000,
    parameter int QUIET_CYC = 1000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run_i,
    input  logic       sound_i,
    input  logic       hard_i,
    input  logic       ocp_i,
    input  logic       tw_i,
    output agc_state_e st_o,
    output logic       diag_o
);

    localparam int MAXC = (RETRY_CYC > QUIET_CYC) ? RETRY_CYC : QUIET_CYC;
    localparam int CW   = $clog2(MAXC + 1);
    localparam logic [CW-1:0] RETRY_LD = CW'(RETRY_CYC - 1);
    localparam logic [CW-1:0] QUIET_LD = CW'(QUIET_CYC - 1);
    localparam logic [CW-1:0] CNT_TOP  = CW'(MAXC - 1);

    typedef struct packed {
        agc_state_e    st;
        logic [CW-1:0] cnt;
        logic          diag;
    } fsm_t;

    fsm_t cur_q, nxt_d;
    logic was_float;

    always_comb begin
        nxt_d     = cur_q;
        was_float = (cur_q.st == ST_SLEEP) || (cur_q.st == ST_FAULT) ||
                    (cur_q.st == ST_RETRY);
        if (hard_i) begin
            nxt_d.st  = ST_FAULT;
            nxt_d.cnt = '0;
        end else if (cur_q.st == ST_RETRY && (cur_q.cnt != '0 || ocp_i)) begin
            nxt_d.st  = ST_RETRY;
            nxt_d.cnt = (cur_q.cnt != '0) ? cur_q.cnt - CW'(1) : RETRY_LD;
        end else if (ocp_i && cur_q.st != ST_RETRY) begin
            nxt_d.st  = ST_RETRY;
            nxt_d.cnt = RETRY_LD;
        end else if (!run_i) begin
            nxt_d.st  = ST_SLEEP;
            nxt_d.cnt = '0;
        end else if (tw_i) begin
            nxt_d.st  = ST_WARN;
            nxt_d.cnt = '0;
        end else if (was_float) begin
            nxt_d.st  = ST_QUIET;
            nxt_d.cnt = QUIET_LD;
        end else if (cur_q.st == ST_QUIET && cur_q.cnt != '0) begin
            nxt_d.cnt = cur_q.cnt - CW'(1);
        end else begin
            nxt_d.st  = sound_i ? ST_PLAY : ST_MUTE;
            nxt_d.cnt = '0;
        end
        nxt_d.diag = !(hard_i || ocp_i || tw_i || nxt_d.st == ST_RETRY);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q.st   <= ST_SLEEP;
            cur_q.cnt  <= '0;
            cur_q.diag <= 1'b1;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign st_o   = cur_q.st;
    assign diag_o = cur_q.diag;

    // R4
    fault_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hard_i |=> (cur_q.st == ST_FAULT));

    // R7
    diag_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hard_i || ocp_i || tw_i) |=> !cur_q.diag);

    // R5
    retry_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.st == ST_RETRY && cur_q.cnt != '0 && !hard_i) |=> (cur_q.st == ST_RETRY));

    // R9
    no_direct_play_chk: assert property (@(posedge clk) disable iff (!rst_n)
        was_float |=> (cur_q.st != ST_PLAY));

    // R1
    sleep_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_i && !hard_i && !ocp_i && cur_q.st != ST_RETRY) |=> (cur_q.st == ST_SLEEP));

    // R5
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cur_q.cnt <= CNT_TOP);

endmodule

// File: rtl/agc_outdrv.sv
module agc_outdrv
    import agc_pkg::*;
#(
    parameter int NCH = 2
) (
    input  agc_state_e       st_i,
    output logic [2*NCH-1:0] cmd_o
);

    chan_cmd_e shared_cmd;
    assign shared_cmd = cmd_of(st_i);

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        assign cmd_o[2*c +: 2] = shared_cmd;
    end

endmodule

// File: rtl/amp_guard_ctrl.sv
module amp_guard_ctrl
    import agc_pkg::*;
#(
    parameter int NCH         = 2,
    parameter int SYNC_STAGES = 2,
    parameter int RETRY_CYC   = 20000,
    parameter int QUIET_CYC   = 1000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_en,
    input  logic             sound_en,
    input  logic             ov_flag,
    input  logic             uv_flag,
    input  logic             oc_flag,
    input  logic             tw_flag,
    input  logic             tsd_flag,
    output logic [2*NCH-1:0] chan_cmd,
    output logic             diag_drive
);

    localparam int NIN = 7;

    logic [NIN-1:0] raw_vec, syn_vec;
    agc_state_e     st;
    logic           hard_s;

    assign raw_vec = {run_en, sound_en, ov_flag, uv_flag, oc_flag, tw_flag, tsd_flag};
    assign hard_s  = syn_vec[4] | syn_vec[3] | syn_vec[0];

    agc_sync #(.W(NIN), .STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw_i  (raw_vec),
        .sync_o (syn_vec)
    );

    agc_fsm #(.RETRY_CYC(RETRY_CYC), .QUIET_CYC(QUIET_CYC)) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .run_i   (syn_vec[6]),
        .sound_i (syn_vec[5]),
        .hard_i  (hard_s),
        .ocp_i   (syn_vec[2]),
        .tw_i    (syn_vec[1]),
        .st_o    (st),
        .diag_o  (diag_drive)
    );

    agc_outdrv #(.NCH(NCH)) u_out (
        .st_i  (st),
        .cmd_o (chan_cmd)
    );

endmodule

// File: tb/tb_amp_guard_ctrl.sv
`timescale 1ns/1ps
module tb_amp_guard_ctrl;

    localparam int NCH = 2;
    localparam int RC  = 6;
    localparam int QC  = 4;
    localparam int SETTLE = 3 + RC + QC + 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic run_en = 0, sound_en = 0, ov_flag = 0, uv_flag = 0;
    logic oc_flag = 0, tw_flag = 0, tsd_flag = 0;
    logic [2*NCH-1:0] chan_cmd;
    logic diag_drive;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    amp_guard_ctrl #(.NCH(NCH), .SYNC_STAGES(2), .RETRY_CYC(RC), .QUIET_CYC(QC)) dut (
        .clk(clk), .rst_n(rst_n), .run_en(run_en), .sound_en(sound_en),
        .ov_flag(ov_flag), .uv_flag(uv_flag), .oc_flag(oc_flag),
        .tw_flag(tw_flag), .tsd_flag(tsd_flag),
        .chan_cmd(chan_cmd), .diag_drive(diag_drive)
    );

    task automatic drive(input logic [6:0] v);
        {run_en, sound_en, ov_flag, uv_flag, oc_flag, tw_flag, tsd_flag} = v;
    endtask

    task automatic wait_k(input int k);
        repeat (k) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input string tag, input logic [1:0] exp_cmd, input logic exp_diag);
        logic [2*NCH-1:0] exp_vec;
        exp_vec = {NCH{exp_cmd}};
        checks++;
        if (chan_cmd !== exp_vec || diag_drive !== exp_diag) begin
            errors++;
            $display("FAIL %s: cmd=%b diag=%b expected cmd=%b diag=%b",
                     tag, chan_cmd, diag_drive, exp_vec, exp_diag);
        end
    endtask

    // steady-state model: R8 priority ladder
    function automatic logic [2:0] model(input logic [6:0] v);
        logic hard;
        logic [1:0] c;
        hard = v[4] | v[3] | v[0];
        if (hard)       c = 2'b00;
        else if (v[2])  c = 2'b00;
        else if (!v[6]) c = 2'b00;
        else if (v[1])  c = 2'b01;
        else if (!v[5]) c = 2'b01;
        else            c = 2'b10;
        return {c, !(hard | v[2] | v[1])};
    endfunction

    function automatic string tag_of(input logic [6:0] v);
        if (v[4] | v[3] | v[0]) return "R8,R4";
        if (v[2])               return "R8,R5";
        if (!v[6])              return "R8,R1";
        if (v[1])               return "R8,R6";
        if (!v[5])              return "R8,R2";
        return "R8,R3";
    endfunction

    localparam logic [6:0] BASE = 7'b1100000;

    initial begin
        drive(7'b0);
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R11 reset", 2'b00, 1'b1);
        rst_n = 1'b1;
        wait_k(2);
        check("R1 sleep after reset", 2'b00, 1'b1);

        drive(BASE);
        wait_k(2);
        check("R10 unchanged after two edges", 2'b00, 1'b1);
        wait_k(1);
        check("R9 idle hold start", 2'b01, 1'b1);
        wait_k(QC - 1);
        check("R9 idle hold last cycle", 2'b01, 1'b1);
        wait_k(1);
        check("R3 play", 2'b10, 1'b1);

        drive(7'b1000000);
        wait_k(2);
        check("R10 mute not yet", 2'b10, 1'b1);
        wait_k(1);
        check("R2 mute", 2'b01, 1'b1);
        drive(BASE);
        wait_k(3);
        check("R2 unmute direct", 2'b10, 1'b1);

        drive(7'b1100010);
        wait_k(3);
        check("R6 warning idles", 2'b01, 1'b0);
        drive(BASE);
        wait_k(3);
        check("R6 warning clears direct", 2'b10, 1'b1);

        drive(7'b1110000);
        wait_k(3);
        check("R4 overvoltage floats", 2'b00, 1'b0);
        wait_k(5);
        drive(BASE);
        wait_k(3);
        check("R9 idle after fault", 2'b01, 1'b1);
        wait_k(QC - 1);
        check("R9 idle after fault end", 2'b01, 1'b1);
        wait_k(1);
        check("R4 auto recovery", 2'b10, 1'b1);

        drive(7'b1100100);
        wait_k(1);
        drive(BASE);
        wait_k(2);
        check("R5 retry entered", 2'b00, 1'b0);
        wait_k(RC - 1);
        check("R5 retry last cycle", 2'b00, 1'b0);
        wait_k(1);
        check("R5 retry ended", 2'b01, 1'b1);
        wait_k(QC - 1);
        check("R9 idle after retry", 2'b01, 1'b1);
        wait_k(1);
        check("R5 play after retry", 2'b10, 1'b1);

        drive(7'b1100100);
        wait_k(2 * RC + 3);
        check("R5 retry repeats", 2'b00, 1'b0);
        drive(BASE);
        wait_k(SETTLE + RC);
        check("R5 recovery after persistent", 2'b10, 1'b1);

        for (int i = 0; i < 128; i++) begin
            logic [2:0] e;
            drive(7'(i));
            wait_k(SETTLE);
            e = model(7'(i));
            check(tag_of(7'(i)), e[2:1], e[0]);
            drive(BASE);
            wait_k(SETTLE);
            check("R9 back to play", 2'b10, 1'b1);
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not complete");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule